// File: doc/BRIEF.md
# Divide-by-2/3 Prescaler Stage with Modulus Control

This block is one stage of a ripple multi-modulus divider. It counts cycles of its own input clock and produces a divided clock for the next, slower stage. Each output period is normally two input cycles long. The stage stretches a period to three input cycles when two things are true at its decision point: the modulus request from the downstream stage is high, and the local program bit is high.

The stage also produces a one-cycle modulus pulse for the upstream stage. It does this for every output period in which it saw a modulus request. The request therefore travels back up the chain, one stage per output period. All state sits in flip-flops on the input clock. An asynchronous active-low reset acts only on those flip-flops and never enters the next-state logic.

Each output period has three possible phases. The first cycle (phase LOW) drives the divided clock low. The second cycle (phase HIGH) drives it high and is the decision point. The optional third cycle (phase EXTRA) also drives it high.

Top module: `mc23_cell`

## Requirements
- R1: While `mod_in` is low at every decision point, `div_out` has a period of exactly 2 input cycles whatever `prog` does, and `mod_out` stays low.
- R2: When `mod_in` = 1 and `prog` = 1 at a decision point, that output period lasts 3 input cycles.
- R3: When `mod_in` = 1 and `prog` = 0 at a decision point, that output period lasts 2 input cycles.
- R4: `mod_out` is high for exactly one input cycle per output period whose decision point saw `mod_in` = 1. That cycle is the one in which `div_out` is low, so `mod_out` has the output's period while `mod_in` stays high.
- R5: The decision point is the input clock edge that ends the single high cycle (phase HIGH) right after `div_out` rises. A `mod_in` pulse one input cycle wide, present only at that edge, is enough to trigger a stretch and a `mod_out` pulse.
- R6: While `rst_n` is low, `div_out` and `mod_out` are 0. At the first clock edge after release, `div_out` goes to 1.
- R7: `prog` is sampled only when `mod_in` is high at the decision point. Toggling `prog` while `mod_in` is low has no effect on `div_out`.
- R8: `div_out` is low for exactly one input cycle in each output period and high for the remaining 1 or 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage input clock, the signal being divided |
| rst_n | input | 1 | Asynchronous active-low reset of the state flip-flops |
| prog | input | 1 | Program bit: 1 allows a divide-by-3 period |
| mod_in | input | 1 | Modulus request from the downstream stage |
| div_out | output | 1 | Divided clock to the downstream stage |
| mod_out | output | 1 | Modulus pulse to the upstream stage |

## Verification
Every output is registered. A `mod_in`/`prog` value applied before a decision edge therefore shows up in the period that began at the preceding rising edge of `div_out`. Its `mod_out` pulse appears in the first low cycle after that edge, which is one or two cycles after the decision.

The bench drives inputs on falling clock edges and samples outputs on the next falling edge. It measures whole periods from one rise of `div_out` to the next. It first discards one full period after any change of held inputs, so that each measured period depends only on the settled values.

For single-cycle pulses, the bench aligns the pulse to the falling edge just after a rise of `div_out`. That places the pulse at the decision edge.

// File: rtl/mc23_pkg.sv
package mc23_pkg;

  typedef enum logic [1:0] {
    PH_LOW   = 2'd0,
    PH_HIGH  = 2'd1,
    PH_EXTRA = 2'd2
  } phase_t;

  localparam int unsigned BASE_CYCLES = 2;

  // phase following the current one
  function automatic phase_t step_phase(input phase_t ph, input logic req, input logic pb);
    case (ph)
      PH_LOW:  return PH_HIGH;
      PH_HIGH: return (req && pb) ? PH_EXTRA : PH_LOW;
      default: return PH_LOW;
    endcase
  endfunction

  // length of an output period decided with these inputs
  function automatic int unsigned period_cycles(input logic req, input logic pb);
    return BASE_CYCLES + ((req && pb) ? 1 : 0);
  endfunction

  // divided clock level in a given phase
  function automatic logic phase_level(input phase_t ph);
    return (ph != PH_LOW);
  endfunction

endpackage

// File: rtl/mc23_seq.sv
module mc23_seq
  import mc23_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   prog,
  input  logic   mod_in,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   req_seen,
  output logic   req_nxt
);

  phase_t ph_q;
  logic   req_q;

  assign phase_nxt = step_phase(ph_q, mod_in, prog);

  // request flag: captured at decision, held through the stretched cycle
  always_comb begin
    case (ph_q)
      PH_HIGH:  req_nxt = mod_in;
      PH_EXTRA: req_nxt = req_q;
      default:  req_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOW;
      req_q <= 1'b0;
    end else begin
      ph_q  <= phase_nxt;
      req_q <= req_nxt;
    end
  end

  assign phase    = ph_q;
  assign req_seen = req_q;

endmodule

// File: rtl/mc23_drv.sv
module mc23_drv
  import mc23_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_nxt,
  input  logic   req_nxt,
  output logic   div_q,
  output logic   mod_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      mod_q <= 1'b0;
    end else begin
      div_q <= phase_level(phase_nxt);
      mod_q <= (phase_nxt == PH_LOW) && req_nxt;
    end
  end

endmodule

// File: rtl/mc23_cell.sv
module mc23_cell
  import mc23_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog,
  input  logic mod_in,
  output logic div_out,
  output logic mod_out
);

  phase_t phase;
  phase_t phase_nxt;
  logic   req_seen;
  logic   req_nxt;
  logic   at_decision;

  assign at_decision = (phase == PH_HIGH);

  mc23_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog      (prog),
    .mod_in    (mod_in),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .req_seen  (req_seen),
    .req_nxt   (req_nxt)
  );

  mc23_drv u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_nxt (phase_nxt),
    .req_nxt   (req_nxt),
    .div_q     (div_out),
    .mod_q     (mod_out)
  );

endmodule

// File: rtl/mc23_chk.sv
module mc23_chk
  import mc23_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   prog,
  input logic   mod_in,
  input logic   div_out,
  input logic   mod_out,
  input phase_t phase,
  input logic   at_decision
);

  AST_STRETCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decision && mod_in && prog) |=> (phase == PH_EXTRA)); // R2

  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decision && !(mod_in && prog)) |=> (phase == PH_LOW)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decision && !mod_in) |=> !mod_out); // R1

  AST_MOD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mod_out |=> !mod_out); // R4

  AST_MOD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mod_out |-> !div_out); // R4

  AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_out) |=> div_out); // R8

  AST_EXTRA_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXTRA) |=> !div_out); // R8

endmodule

bind mc23_cell mc23_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog        (prog),
  .mod_in      (mod_in),
  .div_out     (div_out),
  .mod_out     (mod_out),
  .phase       (phase),
  .at_decision (at_decision)
);

// File: tb/tb_mc23_cell.sv
`timescale 1ns/1ps
module tb_mc23_cell;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog = 1'b0;
  logic mod_in = 1'b0;
  logic div_out;
  logic mod_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc23_cell dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog    (prog),
    .mod_in  (mod_in),
    .div_out (div_out),
    .mod_out (mod_out)
  );

  // {mod_in, prog, period, mod_out cycles, low cycles}
  localparam int NV = 4;
  localparam int VEC [NV][5] = '{
    '{0, 0, 2, 0, 1},
    '{0, 1, 2, 0, 1},
    '{1, 0, 2, 1, 1},
    '{1, 1, 3, 1, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the falling edge where div_out is first seen high
  task automatic wait_rise();
    logic prev;
    bit hit;
    prev = div_out;
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      if (div_out && !prev) hit = 1'b1;
      prev = div_out;
    end
  endtask

  task automatic measure(output int per, output int mo, output int lo);
    logic prev;
    bit hit;
    per = 0; mo = 0; lo = 0;
    prev = div_out;
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      per++;
      if (mod_out) mo++;
      if (!div_out) lo++;
      if (div_out && !prev) hit = 1'b1;
      prev = div_out;
    end
  endtask

  initial begin
    int per, mo, lo, rises;
    // R6 reset state
    repeat (3) @(negedge clk);
    check("R6 div_out in reset", int'(div_out), 0);
    check("R6 mod_out in reset", int'(mod_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 div_out after release", int'(div_out), 1);

    // table walk: R1 R2 R3 R4 R8
    for (int v = 0; v < NV; v++) begin
      mod_in = VEC[v][0][0];
      prog   = VEC[v][1][0];
      wait_rise();
      wait_rise();
      for (int k = 0; k < 2; k++) begin
        measure(per, mo, lo);
        check($sformatf("R1/R2/R3 period mi=%0d c=%0d", VEC[v][0], VEC[v][1]), per, VEC[v][2]);
        check($sformatf("R4 mod_out width mi=%0d c=%0d", VEC[v][0], VEC[v][1]), mo, VEC[v][3]);
        check($sformatf("R8 low cycles mi=%0d c=%0d", VEC[v][0], VEC[v][1]), lo, VEC[v][4]);
      end
    end

    // R5: single-cycle request aligned to the decision edge
    for (int c = 0; c < 2; c++) begin
      mod_in = 1'b0;
      prog = 1'(c);
      wait_rise();
      wait_rise();
      mod_in = 1'b1;
      @(negedge clk);
      mod_in = 1'b0;
      per = 1; mo = 0;
      if (mod_out) mo++;
      begin
        int p2, m2, l2;
        if (div_out) begin
          measure(p2, m2, l2);
          per += p2; mo += m2;
        end else begin
          // already in the low cycle of a 2-cycle period
          measure(p2, m2, l2);
          per += p2; mo += m2;
        end
      end
      check($sformatf("R5 pulse period c=%0d", c), per, c ? 3 : 2);
      check($sformatf("R5 pulse mod_out c=%0d", c), mo, 1);
      measure(per, mo, lo);
      check($sformatf("R5 following period c=%0d", c), per, 2);
      check($sformatf("R5 following mod_out c=%0d", c), mo, 0);
    end

    // R7: prog toggling with mod_in low changes nothing
    mod_in = 1'b0;
    wait_rise();
    rises = 0;
    mo = 0;
    begin
      logic prev;
      prev = div_out;
      for (int i = 0; i < 12; i++) begin
        prog = ~prog;
        @(negedge clk);
        if (div_out && !prev) rises++;
        if (mod_out) mo++;
        prev = div_out;
      end
    end
    check("R7 rises over 12 cycles", rises, 6);
    check("R7 mod_out while idle", mo, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule